// File: doc/BRIEF.md
# Pointer-Plus-Literal Byte Instruction Executor

This block carries out three one-word byte instructions whose operand sits at a computed data address. The address is a 16-bit pointer register plus an unsigned literal held in the low byte of the instruction word. The supported operations are:

- adding the working register to the addressed byte;
- setting a single bit of the addressed byte;
- writing all ones to the addressed byte.

Every accepted instruction runs through the same four phases, one clock each: decode, operand read, process, destination write. It then gives a one-clock completion pulse.

A host loads the pointer and working registers through dedicated load ports while the block is idle. It then strobes `start` with an instruction word. The block drives a byte-wide memory port with combinational read data and a write strobe. It reports arithmetic status flags, and it flags literals outside the legal range and instruction words it does not recognise.

Top module: `idx_exec`

## Requirements
- R1: During and after reset, `busy`, `done`, `bad_op`, `mem_re` and `mem_we` are 0, and the working register, pointer register and all five status flags read 0.
- R2: While `busy` is 0, `ptr_load` loads `ptr_din` into the pointer register and `w_load` loads `w_din` into the working register, each on the next clock edge. While `busy` is 1, both load ports have no effect.
- R3: The operand address on `mem_addr` is the pointer register plus the zero-extended instruction bits [7:0], wrapping modulo 2^16. It is valid during the read phase and during the write phase.
- R4: The word pattern 0010 01d0 kkkk kkkk (bits [15:10]=001001, bit 8=0, d in bit 9) adds the working register to the operand. With d=0 the sum goes to the working register and no memory write occurs. With d=1 the sum is written to memory and the working register is unchanged.
- R5: After an add, the flags hold these values: negative is result bit 7; zero is set when the result is 00h; carry is the carry out of bit 7; digit carry is the carry out of bit 3; overflow is set when both addends share a sign that the result lacks.
- R6: The pattern 1000 bbb0 kkkk kkkk (bits [15:12]=1000, bit 8=0, bit number b in bits [11:9]) writes the operand with bit b set. The flags are unchanged.
- R7: The pattern 0110 1000 kkkk kkkk (bits [15:8]=68h) writes FFh to the operand address. The flags are unchanged.
- R8: If `start` is high at an edge while idle, that edge begins decode. The following three edges end the read, process and write phases. `mem_re` is high only in the read phase and `mem_we` only in the write phase. `busy` stays high across the four phases, and `done` is high for exactly the one cycle after the write phase.
- R9: A `start` strobe while `busy` is 1 is ignored. No further instruction begins once the current one completes.
- R10: A literal above 95 (5Fh), or a word matching none of the three patterns, causes no memory write and no change to the working register or flags. The instruction still completes on the normal schedule, with `bad_op` high in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin executing `instr` when idle |
| instr | input | 16 | Instruction word |
| ptr_load | input | 1 | Load pointer register from `ptr_din` |
| ptr_din | input | 16 | Pointer load value |
| w_load | input | 1 | Load working register from `w_din` |
| w_din | input | 8 | Working register load value |
| mem_addr | output | 16 | Operand address |
| mem_re | output | 1 | Read phase strobe |
| mem_rdata | input | 8 | Combinational read data for `mem_addr` |
| mem_we | output | 1 | Write strobe, write phase only |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_op | output | 1 | Illegal literal or unknown word, valid with `done` |
| w_out | output | 8 | Working register |
| ptr_out | output | 16 | Pointer register |
| st_neg | output | 1 | Negative flag |
| st_ovf | output | 1 | Overflow flag |
| st_carry | output | 1 | Carry flag |
| st_dcarry | output | 1 | Digit carry flag |
| st_zero | output | 1 | Zero flag |

## Verification
Counting from the edge that accepts `start`, each result has a fixed due time. The read strobe and address are due one cycle later. The write strobe and write data are due in the third cycle after that. The completion pulse, `bad_op`, the updated working register, the flags and the stored byte all become visible together in the fourth cycle. The bench drives each instruction from a task that steps one falling edge at a time and samples each of these at its own phase. It also confirms that the cycle after `done` is idle. Stray `start` and load strobes injected during the decode phase are checked afterwards through the pointer and working-register outputs and the idle state.

// File: rtl/idx_exec_pkg.sv
package idx_exec_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DEC  = 3'd1,
    PH_RD   = 3'd2,
    PH_PROC = 3'd3,
    PH_WR   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_BSET = 2'd2,
    OP_FILL = 2'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic ov;
    logic c;
    logic dc;
    logic z;
  } flags_t;

endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_exec_pkg::*;
#(
  parameter int KW    = 8,
  parameter int BW    = 3,
  parameter int K_MAX = 95
) (
  input  logic [15:0]   instr,
  output op_e           op,
  output logic [KW-1:0] k,
  output logic          dest_mem,
  output logic [BW-1:0] bit_sel,
  output logic          illegal
);

  logic is_add, is_bset, is_fill, k_bad;

  always_comb begin
    is_add   = (instr[15:10] == 6'b001001) && !instr[8];
    is_bset  = (instr[15:12] == 4'b1000) && !instr[8];
    is_fill  = (instr[15:8] == 8'h68);
    k        = instr[KW-1:0];
    k_bad    = (int'(k) > K_MAX);
    dest_mem = instr[9];
    bit_sel  = instr[9 +: BW];
    if (is_add)       op = OP_ADD;
    else if (is_bset) op = OP_BSET;
    else if (is_fill) op = OP_FILL;
    else              op = OP_NONE;
    illegal  = (op == OP_NONE) || k_bad;
  end

endmodule

// File: rtl/idx_alu.sv
module idx_alu
  import idx_exec_pkg::*;
#(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  op_e           op,
  input  logic [DW-1:0] w_val,
  input  logic [DW-1:0] opnd,
  input  logic [BW-1:0] bit_sel,
  output logic [DW-1:0] result,
  output flags_t        add_flags
);

  localparam int HALF = DW / 2;

  logic [DW:0]   sum_full;
  logic [HALF:0] sum_low;
  logic [DW-1:0] bit_mask;

  always_comb begin
    sum_full = {1'b0, w_val} + {1'b0, opnd};
    sum_low  = {1'b0, w_val[HALF-1:0]} + {1'b0, opnd[HALF-1:0]};
    bit_mask = '0;
    bit_mask[bit_sel] = 1'b1;

    add_flags.n  = sum_full[DW-1];
    add_flags.z  = (sum_full[DW-1:0] == '0);
    add_flags.c  = sum_full[DW];
    add_flags.dc = sum_low[HALF];
    add_flags.ov = (w_val[DW-1] == opnd[DW-1]) && (sum_full[DW-1] != w_val[DW-1]);

    unique case (op)
      OP_ADD:  result = sum_full[DW-1:0];
      OP_BSET: result = opnd | bit_mask;
      OP_FILL: result = '1;
      default: result = opnd;
    endcase
  end

endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_exec_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   accept,
  output logic   busy,
  output logic   done
);

  phase_e ph_q, ph_d;
  logic   done_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start) ph_d = PH_DEC;
      PH_DEC:  ph_d = PH_RD;
      PH_RD:   ph_d = PH_PROC;
      PH_PROC: ph_d = PH_WR;
      PH_WR:   ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q == PH_WR);
    end
  end

  assign phase  = ph_q;
  assign accept = (ph_q == PH_IDLE) && start;
  assign busy   = (ph_q != PH_IDLE);
  assign done   = done_q;

  // R8: fixed phase order
  a_r8_dec_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_DEC |=> ph_q == PH_RD);
  a_r8_read_to_proc: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_RD |=> ph_q == PH_PROC);
  a_r8_proc_to_write: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q == PH_PROC |=> ph_q == PH_WR);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: an instruction in flight is never restarted
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph_q != PH_WR) |=> busy && ph_q != PH_DEC);

endmodule

// File: rtl/idx_exec.sv
module idx_exec
  import idx_exec_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int K_MAX = 95
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_din,
  input  logic          w_load,
  input  logic [DW-1:0] w_din,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          bad_op,
  output logic [DW-1:0] w_out,
  output logic [AW-1:0] ptr_out,
  output logic          st_neg,
  output logic          st_ovf,
  output logic          st_carry,
  output logic          st_dcarry,
  output logic          st_zero
);

  localparam int KW = 8;
  localparam int BW = $clog2(DW);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_i  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_i  <= rst_meta;
    end
  end

  phase_e        phase;
  logic          accept;
  op_e           op;
  logic [KW-1:0] k;
  logic          dest_mem, illegal;
  logic [BW-1:0] bit_sel;
  logic [DW-1:0] alu_res;
  flags_t        alu_flags;

  logic [15:0]   ir_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] w_q, w_d, opnd_q, res_q;
  flags_t        flags_q, flg_new_q;
  logic          bad_q;

  logic en_ir, en_ptr, en_w, en_opnd, en_res, en_flags, w_from_alu;

  idx_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (start),
    .phase (phase),
    .accept(accept),
    .busy  (busy),
    .done  (done)
  );

  idx_decode #(.KW(KW), .BW(BW), .K_MAX(K_MAX)) u_dec (
    .instr   (ir_q),
    .op      (op),
    .k       (k),
    .dest_mem(dest_mem),
    .bit_sel (bit_sel),
    .illegal (illegal)
  );

  idx_alu #(.DW(DW), .BW(BW)) u_alu (
    .op       (op),
    .w_val    (w_q),
    .opnd     (opnd_q),
    .bit_sel  (bit_sel),
    .result   (alu_res),
    .add_flags(alu_flags)
  );

  always_comb begin
    w_from_alu = (phase == PH_WR) && !illegal && (op == OP_ADD) && !dest_mem;
    en_ir      = accept;
    en_ptr     = ptr_load && !busy;
    en_w       = (w_load && !busy) || w_from_alu;
    w_d        = w_from_alu ? res_q : w_din;
    en_opnd    = (phase == PH_RD);
    en_res     = (phase == PH_PROC);
    en_flags   = (phase == PH_WR) && !illegal && (op == OP_ADD);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ir_q      <= '0;
      ptr_q     <= '0;
      w_q       <= '0;
      opnd_q    <= '0;
      res_q     <= '0;
      flags_q   <= '0;
      flg_new_q <= '0;
      bad_q     <= 1'b0;
    end else begin
      if (en_ir)    ir_q    <= instr;
      if (en_ptr)   ptr_q   <= ptr_din;
      if (en_w)     w_q     <= w_d;
      if (en_opnd)  opnd_q  <= mem_rdata;
      if (en_res) begin
        res_q     <= alu_res;
        flg_new_q <= alu_flags;
      end
      if (en_flags) flags_q <= flg_new_q;
      bad_q <= (phase == PH_WR) && illegal;
    end
  end

  assign mem_addr  = ptr_q + AW'(k);
  assign mem_re    = (phase == PH_RD);
  assign mem_we    = (phase == PH_WR) && !illegal && ((op != OP_ADD) || dest_mem);
  assign mem_wdata = res_q;
  assign bad_op    = bad_q;
  assign w_out     = w_q;
  assign ptr_out   = ptr_q;
  assign st_neg    = flags_q.n;
  assign st_ovf    = flags_q.ov;
  assign st_carry  = flags_q.c;
  assign st_dcarry = flags_q.dc;
  assign st_zero   = flags_q.z;

  // R8: memory strobes confined to their phases
  a_r8_we_phase: assert property (@(posedge clk) disable iff (!rst_n_i)
    mem_we |-> phase == PH_WR);
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> $past(phase == PH_WR));
  // R2: load ports inert while busy
  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    busy |=> $stable(ptr_q));
  // R10: rejected instructions leave state alone
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    (phase == PH_WR && illegal) |=> $stable(flags_q) && $stable(w_q) && bad_op);
  // R6 / R7: non-add instructions keep the flags
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (phase == PH_WR && op != OP_ADD) |=> $stable(flags_q));
  // R4: memory-destination add keeps the working register
  a_r4_w_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    (phase == PH_WR && op == OP_ADD && dest_mem) |=> $stable(w_q));

endmodule

// File: tb/tb_idx_exec.sv
`timescale 1ns/1ps
module tb_idx_exec;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, ptr_load, w_load;
  logic [15:0] instr, ptr_din;
  logic [7:0]  w_din;
  logic [15:0] mem_addr, ptr_out;
  logic        mem_re, mem_we, busy, done, bad_op;
  logic [7:0]  mem_rdata, mem_wdata, w_out;
  logic        st_neg, st_ovf, st_carry, st_dcarry, st_zero;

  always #5 clk = ~clk;

  idx_exec dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .ptr_load(ptr_load), .ptr_din(ptr_din), .w_load(w_load), .w_din(w_din),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .bad_op(bad_op), .w_out(w_out), .ptr_out(ptr_out),
    .st_neg(st_neg), .st_ovf(st_ovf), .st_carry(st_carry),
    .st_dcarry(st_dcarry), .st_zero(st_zero)
  );

  logic [7:0] mem  [256];
  logic [7:0] emem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_ptr;
  logic [7:0]  m_w;
  logic [4:0]  m_fl;   // {n, ov, c, dc, z}

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] add_ref(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    logic [4:0] lo;
    logic [4:0] f;
    s    = {1'b0, a} + {1'b0, b};
    lo   = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    f[4] = s[7];
    f[3] = (a[7] == b[7]) && (s[7] != a[7]);
    f[2] = s[8];
    f[1] = lo[4];
    f[0] = (s[7:0] == 8'h00);
    return {f, s[7:0]};
  endfunction

  function automatic logic [4:0] flags_now();
    return {st_neg, st_ovf, st_carry, st_dcarry, st_zero};
  endfunction

  task automatic load_ptr(input logic [15:0] v);
    @(negedge clk); ptr_load = 1'b1; ptr_din = v;
    @(negedge clk); ptr_load = 1'b0;
    m_ptr = v;
    chk("R2", "pointer load", ptr_out, v);
  endtask

  task automatic load_w(input logic [7:0] v);
    @(negedge clk); w_load = 1'b1; w_din = v;
    @(negedge clk); w_load = 1'b0;
    m_w = v;
    chk("R2", "working load", w_out, v);
  endtask

  task automatic exec(input logic [15:0] iw, input bit poke);
    logic [7:0]  k, opv, wv;
    logic [15:0] ea;
    logic        is_add, is_bs, is_fill, ill, exp_we;
    logic [12:0] ar;
    k       = iw[7:0];
    is_add  = (iw[15:10] == 6'b001001) && !iw[8];
    is_bs   = (iw[15:12] == 4'b1000) && !iw[8];
    is_fill = (iw[15:8] == 8'h68);
    ill     = !(is_add || is_bs || is_fill) || (k > 8'd95);
    ea      = m_ptr + {8'h00, k};
    opv     = emem[ea[7:0]];
    exp_we  = 1'b0;
    wv      = opv;
    if (!ill) begin
      if (is_add) begin
        ar   = add_ref(m_w, opv);
        m_fl = ar[12:8];
        if (iw[9]) begin exp_we = 1'b1; wv = ar[7:0]; end
        else m_w = ar[7:0];
      end else if (is_bs) begin
        exp_we = 1'b1; wv = opv | (8'h01 << iw[11:9]);
      end else begin
        exp_we = 1'b1; wv = 8'hFF;
      end
      if (exp_we) emem[ea[7:0]] = wv;
    end

    @(negedge clk); start = 1'b1; instr = iw;
    @(negedge clk); start = 1'b0;                  // decode phase
    chk("R8", "busy in decode", busy, 1'b1);
    if (poke) begin
      start = 1'b1; instr = 16'h6800;
      ptr_load = 1'b1; ptr_din = ~m_ptr;
      w_load = 1'b1;   w_din = ~m_w;
    end
    @(negedge clk);                                // read phase
    start = 1'b0; ptr_load = 1'b0; w_load = 1'b0;
    chk("R8", "read strobe", mem_re, 1'b1);
    chk("R3", "operand address", mem_addr, ea);
    @(negedge clk);                                // process phase
    chk("R8", "no write in process", mem_we, 1'b0);
    @(negedge clk);                                // write phase
    chk(ill ? "R10" : "R8", "write strobe", mem_we, exp_we);
    if (exp_we) begin
      chk("R3", "write address", mem_addr, ea);
      chk(is_add ? "R4" : (is_bs ? "R6" : "R7"), "write data", mem_wdata, wv);
    end
    @(negedge clk);                                // done cycle
    chk("R8", "done pulse", done, 1'b1);
    chk("R10", "bad_op", bad_op, ill);
    chk("R4", "working register", w_out, m_w);
    chk("R5", "flags", flags_now(), m_fl);
    chk(is_bs ? "R6" : "R7", "stored byte", mem[ea[7:0]], emem[ea[7:0]]);
    @(negedge clk);
    chk("R8", "done drops", done, 1'b0);
    chk(poke ? "R9" : "R8", "idle after", busy, 1'b0);
    if (poke) chk("R2", "pointer kept", ptr_out, m_ptr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1DC3));
    start = 0; ptr_load = 0; w_load = 0; instr = 0; ptr_din = 0; w_din = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'($urandom);
      emem[i] = mem[i];
    end
    m_ptr = 0; m_w = 0; m_fl = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "strobes in reset", {mem_re, mem_we, done, bad_op}, 4'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "flags after reset", flags_now(), 5'h00);
    chk("R1", "working after reset", w_out, 8'h00);
    chk("R1", "pointer after reset", ptr_out, 16'h0000);
    chk("R1", "idle after reset", {busy, done, mem_we, mem_re}, 4'h0);

    // directed vectors
    load_ptr(16'h0A00); load_w(8'h17);
    emem[8'h2C] = 8'h20; mem[8'h2C] = 8'h20;
    exec(16'h242C, 0);                 // R4 d=0: W=37h, memory stays 20h
    chk("R4", "d0 result", w_out, 8'h37);
    chk("R4", "d0 memory untouched", mem[8'h2C], 8'h20);
    exec(16'h262C, 0);                 // R4 d=1: memory 57h
    chk("R4", "d1 memory", mem[8'h2C], 8'h57);
    emem[8'h0A] = 8'h55; mem[8'h0A] = 8'h55;
    exec(16'h8E0A, 0);                 // R6 bit 7 set
    chk("R6", "bit7 set", mem[8'h0A], 8'hD5);
    emem[8'h2C] = 8'h00; mem[8'h2C] = 8'h00;
    exec(16'h682C, 0);                 // R7 fill
    chk("R7", "fill", mem[8'h2C], 8'hFF);
    load_w(8'h7F); emem[8'h10] = 8'h01; mem[8'h10] = 8'h01;
    exec(16'h2410, 0);                 // R5 signed overflow
    chk("R5", "overflow flags", flags_now(), 5'b11010);
    load_w(8'hFF);
    exec(16'h2410, 0);                 // R5 carry and zero
    chk("R5", "carry zero flags", flags_now(), 5'b00111);
    exec(16'h245F, 0);                 // R10 k=95 legal
    exec(16'h6860, 0);                 // R10 k=96 rejected
    exec(16'hF123, 1);                 // R10 unknown word, R9 poke
    load_ptr(16'hFFF0);
    exec(16'h685F, 1);                 // R3 wrap to 004Fh, R9 poke

    // constrained random
    for (int it = 0; it < 300; it++) begin
      logic [15:0] iw;
      logic [7:0]  kk;
      int          sel;
      if ($urandom % 4 == 0) load_ptr(16'($urandom));
      if ($urandom % 3 == 0) load_w(8'($urandom));
      kk  = 8'($urandom % 96);
      sel = $urandom % 8;
      case (sel)
        0:       iw = {6'b001001, 1'b0, 1'b0, kk};
        1, 7:    iw = {6'b001001, 1'b1, 1'b0, kk};
        2, 3:    iw = {4'b1000, 3'($urandom), 1'b0, kk};
        4:       iw = {8'h68, kk};
        5:       iw = {8'h68, 8'(96 + $urandom % 160)};
        default: iw = {4'hF, 12'($urandom)};
      endcase
      exec(iw, ($urandom % 3) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule